// File: doc/BRIEF.md
# Masked-Write Two-Pin GPIO Register

This block is one 32-bit register that controls two open-drain pins, used by software as the clock and data lines of a bit-banged I2C or DDC bus. Pin 0 carries the serial clock. Pin 1 carries the serial data. Each pin has two stored bits: a direction bit and an output data bit. Each stored bit has its own write-enable (mask) bit in the same written word. A single store can therefore change one field of one pin and leave everything else as it was. No read-modify-write sequence is needed.

A read returns both stored bits of each pin and the synchronised level present on each pad. A pin whose direction is output and whose data is 0 pulls its line low. In every other state the pin releases the line, and an external pull-up takes it high. Pad inputs pass through a synchroniser chain before they can be read.

Top module: `gpio_pair_reg`

## Requirements
- R1: Synchronous active-low reset clears both direction bits (input) and both data bits to 0. Both `pad_pull_low` outputs are then 0, and the synchroniser stages are preset to 1 (idle-high line).
- R2: A write stores data value bit 11 (pin 1) or bit 3 (pin 0) only when data mask bit 10 (pin 1) or bit 2 (pin 0) is 1 in the same word. The new value reads back from the following cycle on.
- R3: A write stores direction value bit 9 (pin 1) or bit 1 (pin 0) only when direction mask bit 8 (pin 1) or bit 0 (pin 0) is 1 in the same word. A direction of 1 means output and 0 means input.
- R4: A stored bit whose mask is 0 in a write keeps its value, even when the value bit in the word differs. Writing one pin never changes the other pin.
- R5: `pad_pull_low[i]` is 1 exactly when pin i is an output holding data 0. It follows a write from the cycle after the write's clock edge.
- R6: A pad level change shows up in read bit 12 (pin 1) or bit 4 (pin 0) after exactly SYNC_STAGES clock edges, and not before.
- R7: Reads return 0 in the reserved bits 31:13 and 7:5 and in the four mask positions 10, 8, 2 and 0. Writing 1s to those bits changes nothing.
- R8: A write takes effect only when `bus_valid`, `bus_we` and an address equal to REG_ADDR all hold in the same cycle. `bus_rdata` is 0 unless a read of REG_ADDR is presented, and it is valid in the same cycle as that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request strobe |
| bus_addr | input | ADDR_W | Access address |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, combinational during a read |
| pad_in | input | 2 | Sampled line levels, [0] clock, [1] data |
| pad_pull_low | output | 2 | 1 = pull the line low, 0 = release it |

## Verification
The bench builds the block with ADDR_W = 4, REG_ADDR = 5 and SYNC_STAGES = 3. The narrow address makes neighbouring addresses easy to hit, which shows that the decode ignores writes to them. The three-stage chain shows that the input latency follows the parameter rather than a fixed depth of two. The bench models an open-drain line: each pad reads low when either the block or an external device pulls it. Pull-low behaviour and input sampling are therefore checked together.

// File: rtl/gpio_pair_pkg.sv
// Shared field layout for the two-pin masked-write register.
// Assumes every pin owns a 5-bit field at a stride of 8 bits.
package gpio_pair_pkg;
    localparam int NUM_PINS   = 2;
    localparam int PIN_STRIDE = 8;
    localparam int FIELD_W    = 5;
    localparam int REG_W      = 32;

    // Bit positions inside one pin field
    localparam int F_DIR_MSK = 0;
    localparam int F_DIR_VAL = 1;
    localparam int F_DAT_MSK = 2;
    localparam int F_DAT_VAL = 3;
    localparam int F_IN      = 4;

    localparam int PIN_SCL = 0;
    localparam int PIN_SDA = 1;

    // Bits of the word that may read as nonzero
    function automatic logic [REG_W-1:0] live_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            m[p*PIN_STRIDE + F_IN]      = 1'b1;
            m[p*PIN_STRIDE + F_DAT_VAL] = 1'b1;
            m[p*PIN_STRIDE + F_DIR_VAL] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/gpio_sync_chain.sv
// Multi-flop synchroniser for one asynchronous pad level.
// Assumes STAGES >= 2; the stages preset to 1 because the line idles high.
module gpio_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stg_q;

    // Shift the pad level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= {stg_q[STAGES-2:0], async_in};
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_slice.sv
// One pin: stored direction/data bits with per-bit write masks,
// an open-drain pull-low output and a synchronised input sample.
// Assumes wr_stb is already qualified by the bus decode.
module gpio_pin_slice
    import gpio_pair_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic               pad_in,
    output logic               pad_pull_low,
    output logic [FIELD_W-1:0] rd_field
);
    logic dat_q;
    logic dir_q;
    logic in_sync;

    // Masked update of the stored data bit
    always_ff @(posedge clk) begin
        if (!rst_n)                          dat_q <= 1'b0;
        else if (wr_stb && wr_field[F_DAT_MSK]) dat_q <= wr_field[F_DAT_VAL];
    end

    // Masked update of the stored direction bit
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= 1'b0;
        else if (wr_stb && wr_field[F_DIR_MSK]) dir_q <= wr_field[F_DIR_VAL];
    end

    gpio_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    // Open drain: only an output holding 0 pulls the line
    always_comb pad_pull_low = dir_q & ~dat_q;

    // Read field: masks read as zero
    always_comb begin
        rd_field            = '0;
        rd_field[F_IN]      = in_sync;
        rd_field[F_DAT_VAL] = dat_q;
        rd_field[F_DIR_VAL] = dir_q;
    end

    // R2
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_field[F_DAT_MSK]) |=> (dat_q == $past(wr_field[F_DAT_VAL])));
    // R3
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_field[F_DIR_MSK]) |=> (dir_q == $past(wr_field[F_DIR_VAL])));
    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_field[F_DAT_MSK]) |=> $stable(dat_q));
    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_field[F_DIR_MSK]) |=> $stable(dir_q));
    // R5
    drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_field[F_DAT_MSK] && !wr_field[F_DAT_VAL]
                && wr_field[F_DIR_MSK] && wr_field[F_DIR_VAL]) |=> pad_pull_low);
    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_field[F_DIR_MSK] && !wr_field[F_DIR_VAL]) |=> !pad_pull_low);
endmodule

// File: rtl/gpio_pair_reg.sv
// Top: decodes a valid/address/write-enable access to one 32-bit register
// and fans the word out to two pin slices (pin 0 clock, pin 1 data).
// Assumes reads are combinational in the cycle of the request.
module gpio_pair_reg
    import gpio_pair_pkg::*;
#(
    parameter int             ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int             SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_pull_low
);
    localparam logic [REG_W-1:0] LIVE = live_bits();

    logic             hit;
    logic             wr_stb;
    logic             rd_sel;
    logic [REG_W-1:0] word;

    // Address and command decode
    always_comb begin
        hit    = bus_valid && (bus_addr == REG_ADDR);
        wr_stb = hit && bus_we;
        rd_sel = hit && !bus_we;
    end

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [FIELD_W-1:0] rd_f;
            gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
                .clk          (clk),
                .rst_n        (rst_n),
                .wr_stb       (wr_stb),
                .wr_field     (bus_wdata[p*PIN_STRIDE +: FIELD_W]),
                .pad_in       (pad_in[p]),
                .pad_pull_low (pad_pull_low[p]),
                .rd_field     (rd_f)
            );
        end
    endgenerate

    // Assemble the readback word from the slices
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            case (i)
                PIN_SCL: word[PIN_SCL*PIN_STRIDE +: FIELD_W] = g_pin[PIN_SCL].rd_f;
                default: word[PIN_SDA*PIN_STRIDE +: FIELD_W] = g_pin[PIN_SDA].rd_f;
            endcase
        end
    end

    // Drive read data only during a decoded read
    always_comb bus_rdata = rd_sel ? word : '0;

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> ((bus_rdata & ~LIVE) == '0));
    // R8
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(pad_pull_low));
endmodule

// File: tb/gpio_pair_reg_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module gpio_pair_reg_tb;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] RADDR = 4'h5;
    localparam int STAGES = 3;
    localparam logic [31:0] STORE_M = 32'h0000_0A0A;
    localparam logic [31:0] LIVE_M  = 32'h0000_1A1A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0] pad_in;
    logic [1:0] pad_pull_low;
    logic [1:0] ext_low = 2'b00;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Open-drain line model with pull-up
    assign pad_in = ~(pad_pull_low | ext_low);

    gpio_pair_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR), .SYNC_STAGES(STAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_pull_low(pad_pull_low)
    );

    // {write word, expected stored bits, expected pull_low}
    localparam int NV = 12;
    localparam logic [49:0] VEC [NV] = '{
        {32'h0000_0000, 16'h0000, 2'b00},
        {32'h0000_0003, 16'h0002, 2'b01},
        {32'h0000_0300, 16'h0202, 2'b11},
        {32'h0000_000C, 16'h020A, 2'b10},
        {32'hFFFF_E0E0, 16'h020A, 2'b10},
        {32'h0000_0800, 16'h020A, 2'b10},
        {32'h0000_0C08, 16'h0A0A, 2'b00},
        {32'h0000_0102, 16'h080A, 2'b00},
        {32'h0000_0001, 16'h0808, 2'b00},
        {32'h0000_0404, 16'h0000, 2'b00},
        {32'h0000_0F0F, 16'h0A0A, 2'b00},
        {32'h0000_0505, 16'h0000, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic v, input logic we);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_we = we; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(RADDR, rd);
        check("R1 stored bits", rd & STORE_M, 32'h0);
        check("R1 pull_low", {30'h0, pad_pull_low}, 32'h0);

        // Vector walk: R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            bus_write(RADDR, VEC[i][49:18], 1'b1, 1'b1);
            bus_read(RADDR, rd);
            check($sformatf("R2/R3/R4 vec%0d", i), rd & STORE_M, {16'h0, VEC[i][17:2]});
            check($sformatf("R5 vec%0d", i), {30'h0, pad_pull_low}, {30'h0, VEC[i][1:0]});
            check($sformatf("R7 vec%0d", i), rd & ~LIVE_M, 32'h0);
        end

        // R8: wrong address, read command, no valid -> no change (state now 0)
        bus_write(RADDR - 1, 32'h0000_0F0F, 1'b1, 1'b1);
        bus_write(RADDR, 32'h0000_0F0F, 1'b1, 1'b0);
        bus_write(RADDR, 32'h0000_0F0F, 1'b0, 1'b1);
        bus_read(RADDR, rd);
        check("R8 ignored writes", rd & STORE_M, 32'h0);
        bus_write(RADDR, 32'h0000_0F0F, 1'b1, 1'b1);
        bus_read(RADDR + 1, rd);
        check("R8 rdata zero off-address", rd, 32'h0);

        // R6: external low on the data pad, watch latency
        bus_write(RADDR, 32'h0000_0101, 1'b1, 1'b1); // both inputs
        repeat (STAGES + 1) @(negedge clk);
        bus_read(RADDR, rd);
        check("R6 idle high", rd & 32'h1010, 32'h1010);
        @(negedge clk);
        ext_low = 2'b10;
        for (int k = 1; k <= STAGES; k++) begin
            @(posedge clk);
            #1;
            bus_read(RADDR, rd);
            check($sformatf("R6 edge%0d", k), {31'h0, rd[12]}, (k == STAGES) ? 32'h0 : 32'h1);
        end
        check("R6 pin0 unaffected", {31'h0, rd[4]}, 32'h1);
        @(negedge clk);
        ext_low = 2'b00;

        // R5: pin driving low is seen on its own input
        bus_write(RADDR, 32'h0000_0007, 1'b1, 1'b1); // pin0 output, data 0
        repeat (STAGES + 1) @(negedge clk);
        bus_read(RADDR, rd);
        check("R5 self pull seen", {31'h0, rd[4]}, 32'h0);

        // R1: reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(RADDR, rd);
        check("R1 re-reset", (rd & STORE_M) | {30'h0, pad_pull_low}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule